// File: doc/BRIEF.md
# Sleep Wake-up Level Qualifier

This block decides whether a low level on an external interrupt pin should wake a sleeping device, and whether that wake should also carry an interrupt request. While the device sleeps the fast I/O clock is stopped. The block therefore runs entirely on a slow, always-on watchdog clock, nominally 1 µs per period, and samples the active-low pin on each of its rising edges.

A wake is started only when the pin is seen low on two consecutive slow-clock samples. A single low sample is treated as noise, and the block goes back to waiting. Once the level qualifies, a start-up delay runs. Its length in slow-clock cycles is chosen by a 2-bit select. At the end of the delay the block emits a one-cycle wake pulse. If the pin is still low at that moment, it also raises the interrupt request in the same cycle. If the level went away during the delay, the device still wakes but no interrupt is raised.

Deasserting the sleep indication abandons any qualification or start-up in progress and returns the block to idle. A new sleep period begins only on a fresh rising edge of the sleep indication.

Top module: `wake_level_qual`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `wake_o` and `irq_o` are low. Reset is asynchronous active-low and is released synchronously.
- R2: With the block asleep, the pin must be low on two consecutive slow-clock edges to start the start-up delay. If it is low on only one edge and high on the next, the block returns to waiting and produces no wake.
- R3: The start-up length is 2^(2+2·`sup_sel`) slow-clock cycles, which gives 4, 16, 64 and 256 for select values 0, 1, 2 and 3. Number the edges from the first edge at which the pin is sampled low as edge 1. `wake_o` is then high for exactly one cycle, directly after edge 2+length.
- R4: `irq_o` is high in the wake cycle if and only if the pin was sampled low at edge 2+length. Otherwise the wake occurs with `irq_o` low.
- R5: `irq_o` is never high in a cycle where `wake_o` is low.
- R6: When `sleep_i` is low at an edge, the block returns to idle at that edge and clears any start-up count. No wake follows while `sleep_i` stays low, whatever the pin does. A later sleep period starts its delay from zero.
- R7: After a wake, the block stays idle while `sleep_i` remains high, even with the pin held low. Sleep is entered only when `sleep_i` is sampled high on an edge after an edge at which it was sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Always-on slow watchdog clock; the pin is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | High while the device is in a deep sleep mode |
| pin_n | input | 1 | External interrupt pin, active low |
| sup_sel | input | 2 | Start-up length select (0: 4, 1: 16, 2: 64, 3: 256 cycles) |
| wake_o | output | 1 | One-cycle wake pulse at the end of start-up |
| irq_o | output | 1 | Interrupt request, high with the wake pulse when the level persisted |

## Verification
The bench builds the block with its default parameters: a base exponent of 2, an exponent step of 2 and a 2-bit select. These defaults give all four start-up lengths, up to 256 cycles, so every select value is driven. The pin is released exactly one edge before and exactly at the final start-up edge, which exercises both sides of the interrupt decision. Single-sample glitches, an abort of sleep partway through start-up followed by a full-length retry, and a held-low pin after a wake are also covered.

// File: rtl/wake_qual_pkg.sv
package wake_qual_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE   = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_SAMPLE1 = 3'd2,
    ST_STARTUP = 3'd3,
    ST_CHECK   = 3'd4
  } wq_state_e;

endpackage

// File: rtl/wake_qual_rst_sync.sv
module wake_qual_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/wake_qual_startup_cnt.sv
module wake_qual_startup_cnt #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 2,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);

  localparam int NSEL     = 1 << SEL_W;
  localparam int MAX_LOG2 = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);
  localparam int CNT_W    = MAX_LOG2;

  logic [CNT_W-1:0] limit_tab [NSEL];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  for (genvar g = 0; g < NSEL; g++) begin : g_limit
    localparam longint LEN = longint'(1) << (BASE_LOG2 + STEP_LOG2 * g);
    assign limit_tab[g] = CNT_W'(LEN - 1);
  end

  assign limit = limit_tab[sel];
  assign done  = run && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: the count never passes the selected limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

  // R6: a clear leaves the counter at zero
  a_r6_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/wake_qual_fsm.sv
module wake_qual_fsm
  import wake_qual_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic pin_n,
  input  logic cnt_done,
  output logic cnt_run,
  output logic cnt_clr,
  output logic wake_o,
  output logic irq_o
);

  wq_state_e state_q, state_d;
  logic      sleep_q;
  logic      wake_q, wake_d;
  logic      irq_q, irq_d;

  assign cnt_run = (state_q == ST_STARTUP) && sleep_i;
  assign cnt_clr = (state_q != ST_STARTUP) || !sleep_i;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    irq_d   = 1'b0;
    if (!sleep_i) begin
      state_d = ST_AWAKE;
    end else begin
      unique case (state_q)
        ST_AWAKE:   if (!sleep_q) state_d = ST_SLEEP;
        ST_SLEEP:   if (!pin_n) state_d = ST_SAMPLE1;
        ST_SAMPLE1: state_d = pin_n ? ST_SLEEP : ST_STARTUP;
        ST_STARTUP: begin
          if (cnt_done) begin
            state_d = ST_CHECK;
            wake_d  = 1'b1;
            irq_d   = !pin_n;
          end
        end
        ST_CHECK:   state_d = ST_AWAKE;
        default:    state_d = ST_AWAKE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sleep_q <= sleep_i;
      wake_q  <= wake_d;
      irq_q   <= irq_d;
    end
  end

  assign wake_o = wake_q;
  assign irq_o  = irq_q;

  // R5: no interrupt request outside a wake cycle
  a_r5_irq_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> wake_o);

  // R3: the wake pulse lasts one cycle
  a_r3_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R6: sleep low at an edge means no wake in the following cycle
  a_r6_no_wake_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !wake_o);

  // R2: start-up is only entered from the second-sample state
  a_r2_startup_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STARTUP && $past(state_q) != ST_STARTUP) |-> $past(state_q) == ST_SAMPLE1);

  // R4: the interrupt follows the pin level at the final start-up edge
  a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (irq_o == !$past(pin_n)));

endmodule

// File: rtl/wake_level_qual.sv
module wake_level_qual #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 2,
  parameter int STEP_LOG2 = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             pin_n,
  input  logic [SEL_W-1:0] sup_sel,
  output logic             wake_o,
  output logic             irq_o
);

  logic srst_n;
  logic cnt_run;
  logic cnt_clr;
  logic cnt_done;

  wake_qual_rst_sync #(
    .STAGES (SYNC_LEN)
  ) u_rst_sync (
    .clk    (clk_slow),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wake_qual_startup_cnt #(
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2)
  ) u_cnt (
    .clk   (clk_slow),
    .rst_n (srst_n),
    .run   (cnt_run),
    .clr   (cnt_clr),
    .sel   (sup_sel),
    .done  (cnt_done)
  );

  wake_qual_fsm u_fsm (
    .clk      (clk_slow),
    .rst_n    (srst_n),
    .sleep_i  (sleep_i),
    .pin_n    (pin_n),
    .cnt_done (cnt_done),
    .cnt_run  (cnt_run),
    .cnt_clr  (cnt_clr),
    .wake_o   (wake_o),
    .irq_o    (irq_o)
  );

endmodule

// File: tb/wake_level_qual_tb.sv
module wake_level_qual_tb;

  logic       clk_slow = 1'b0;
  logic       rst_n;
  logic       sleep_i;
  logic       pin_n;
  logic [1:0] sup_sel;
  logic       wake_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_slow = ~clk_slow;

  wake_level_qual u_dut (
    .clk_slow (clk_slow),
    .rst_n    (rst_n),
    .sleep_i  (sleep_i),
    .pin_n    (pin_n),
    .sup_sel  (sup_sel),
    .wake_o   (wake_o),
    .irq_o    (irq_o)
  );

  localparam int NV = 10;
  localparam int VSEL  [NV] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 3};
  localparam int VHOLD [NV] = '{6, 5, 1, 2, 18, 17, 66, 65, 258, 100};
  localparam int VWAKE [NV] = '{1, 1, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam int VIRQ  [NV] = '{1, 0, 0, 0, 1, 0, 1, 0, 1, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter_sleep();
    @(negedge clk_slow);
    sleep_i = 1'b0;
    pin_n   = 1'b1;
    @(posedge clk_slow);
    @(negedge clk_slow);
    sleep_i = 1'b1;
    @(posedge clk_slow);
  endtask

  // pin low before edges 1..hold; watch for the wake pulse
  task automatic run_vec(input int sel, input int hold, input int ew, input int ei, input string tag);
    int len = 1 << (2 + 2 * sel);
    int nwake = 0;
    int wcyc = -1;
    int wirq = 0;
    sup_sel = 2'(sel);
    for (int i = 1; i <= len + 8; i++) begin
      @(negedge clk_slow);
      pin_n = (i <= hold) ? 1'b0 : 1'b1;
      @(posedge clk_slow);
      #1;
      if (irq_o && !wake_o) chk(1'b0, "R5", int'(irq_o), 0);
      if (wake_o) begin
        nwake++;
        wcyc = i;
        wirq = int'(irq_o);
      end
    end
    chk(nwake == ew, {tag, " R2 wake count"}, nwake, ew);
    if (ew == 1) begin
      chk(wcyc == len + 2, {tag, " R3 wake cycle"}, wcyc, len + 2);
      chk(wirq == ei, {tag, " R4 irq"}, wirq, ei);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_slow);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    sleep_i = 1'b0;
    pin_n   = 1'b1;
    sup_sel = 2'd0;
    repeat (3) @(posedge clk_slow);
    #1;
    chk(!wake_o && !irq_o, "R1 in reset", int'({wake_o, irq_o}), 0);
    @(negedge clk_slow);
    rst_n = 1'b1;
    repeat (3) @(posedge clk_slow);
    #1;
    chk(!wake_o && !irq_o, "R1 after reset", int'({wake_o, irq_o}), 0);

    // table of vectors: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      enter_sleep();
      run_vec(VSEL[v], VHOLD[v], VWAKE[v], VIRQ[v], $sformatf("vec%0d", v));
    end

    // R6: abort during start-up, no wake while awake
    begin
      int seen = 0;
      enter_sleep();
      sup_sel = 2'd1;
      @(negedge clk_slow);
      pin_n = 1'b0;
      repeat (10) @(posedge clk_slow);
      @(negedge clk_slow);
      sleep_i = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(posedge clk_slow);
        #1;
        if (wake_o) seen++;
      end
      chk(seen == 0, "R6 no wake after abort", seen, 0);
    end
    // R6: next sleep starts the count from zero
    enter_sleep();
    run_vec(1, 18, 1, 1, "R6 restart");

    // R7: sleep held high after wake, pin low, no second wake
    begin
      int seen = 0;
      enter_sleep();
      run_vec(0, 6, 1, 1, "R7 first");
      @(negedge clk_slow);
      pin_n = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk_slow);
        #1;
        if (wake_o) seen++;
      end
      chk(seen == 0, "R7 no rewake", seen, 0);
    end

    // R1: asynchronous reset clears a pending wake
    enter_sleep();
    sup_sel = 2'd0;
    @(negedge clk_slow);
    pin_n = 1'b0;
    repeat (5) @(posedge clk_slow);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk(!wake_o && !irq_o, "R1 async reset", int'({wake_o, irq_o}), 0);
    repeat (4) @(posedge clk_slow);
    #1;
    chk(!wake_o && !irq_o, "R1 held reset", int'({wake_o, irq_o}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule